// File: doc/BRIEF.md
# Lane-Parallel Carry-Less Multiplier

This unit takes two wide operand vectors, cut into independent 128-bit lanes, together with one 8-bit selector byte that all lanes share. In every lane it takes one 64-bit half of operand A and one 64-bit half of operand B. It multiplies them as polynomials over GF(2), so partial products combine by XOR and no carry moves between bit positions. The 128-bit product goes back into the same lane of the result. Lanes never see each other's data. The parameter `LANES` sets the vector width to 256 bits (2 lanes) or 512 bits (4 lanes). The parameter `STAGES` sets the pipeline depth to 1 or 2 registers.

Operands enter and results leave over valid/ready handshakes. A transfer on either side happens on a rising clock edge where valid and ready are both high. While `out_ready` is low, a result that is already shown stays on `out_data` without change and `out_valid` stays high. The pipeline stalls behind it. `in_ready` drops only when no stage could take a new operand set. Results leave in the order their operands arrived. No operand set is lost or repeated.

Top module: `lane_clmul_unit`

## Requirements
- R1: Each lane result is the carry-less (GF(2), XOR-accumulated) product of the selected 64-bit half of A and the selected 64-bit half of B. With A lane = 0x7b5b546573745665_63746f725d53475d and B lane = 0x4869285368617929_5b477565726f6e5d, selector 0x00 gives 0x1d4d84c85c3440c0_929633d5d36f0451 and selector 0x11 gives 0x1d1e1f2c592e7c45_d66ee03e410fd4ed.
- R2: Selector bit 0 picks the half of A in every lane: 0 picks lane bits 63:0 and 1 picks lane bits 127:64.
- R3: Selector bit 4 picks the half of B in every lane: 0 picks lane bits 63:0 and 1 picks lane bits 127:64.
- R4: Selector bits 7:5 and 3:1 have no effect on the result.
- R5: Lane i occupies vector bits 128*i+127 to 128*i for A, B and the result. All lanes use the same selector, and each lane's result depends only on that lane's operands.
- R6: Bit 127 of every lane result is 0. For example, squaring a low half of 0x8000000000000000 gives only bit 126 set.
- R7: Operands are captured on an edge where `in_valid` and `in_ready` are both high. With `out_ready` held high, `out_valid` rises exactly `STAGES` edges after that capture.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is stable. Every captured operand set produces exactly one result, in arrival order.
- R9: A synchronous active-high `rst` clears `out_valid` and all internal valid bits. Operand sets in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can accept an operand set this edge |
| in_a | input | 128*LANES | Operand vector A |
| in_b | input | 128*LANES | Operand vector B |
| in_imm | input | 8 | Half selector shared by all lanes (bit 0 for A, bit 4 for B) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_data | output | 128*LANES | Result vector, one 128-bit product per lane |

## Verification
The bench sends operand sets whose upper and lower halves differ, under all four half selections. If the bench select bits were swapped or read from the wrong place, the product would be formed from the wrong halves and would not match the reference. It also repeats a case with every unused selector bit set, which catches a decoder that reads the whole byte. Random data that differs in every lane is delivered under random back-pressure. This exposes lanes that are mis-sliced or share data, and also any stage that drops, duplicates or reorders results when stalled. Directed cases pin down the fill latency, hold a stalled result for several cycles, and reset a full pipeline. A wrong stage count, a result that changes while stalled, or a reset that leaves stale data would each show up there.

// File: rtl/lclmul_pkg.sv
package lclmul_pkg;
  // Positions inside the shared selector byte; the half choice depends on them.
  localparam int SEL_A_BIT = 0;
  localparam int SEL_B_BIT = 4;
  localparam int SEL_W     = 8;
endpackage

// File: rtl/clmul_half_sel.sv
module clmul_half_sel #(
  parameter int HALF_W = 64
) (
  input  logic [2*HALF_W-1:0] lane_a,
  input  logic [2*HALF_W-1:0] lane_b,
  input  logic                take_a_hi,
  input  logic                take_b_hi,
  output logic [HALF_W-1:0]   a_half,
  output logic [HALF_W-1:0]   b_half
);
  always_comb begin
    a_half = take_a_hi ? lane_a[2*HALF_W-1:HALF_W] : lane_a[HALF_W-1:0];
    b_half = take_b_hi ? lane_b[2*HALF_W-1:HALF_W] : lane_b[HALF_W-1:0];
  end
endmodule

// File: rtl/clmul_core.sv
module clmul_core #(
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0]   mul_a,
  input  logic [HALF_W-1:0]   mul_b,
  output logic [2*HALF_W-1:0] prod
);
  localparam int PROD_W = 2 * HALF_W;

  logic [PROD_W-1:0] a_ext;
  assign a_ext = {{HALF_W{1'b0}}, mul_a};

  // Shift-and-XOR accumulation: one partial product per bit of mul_b.
  always_comb begin
    prod = '0;
    for (int i = 0; i < HALF_W; i++) begin
      if (mul_b[i]) prod = prod ^ (a_ext << i);
    end
  end
endmodule

// File: rtl/clmul_stage.sv
module clmul_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (up_ready) begin
      full_q <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_ready && up_valid) data_q <= up_data;
  end

  AST_STAGE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready) |=> dn_valid); // R7

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data))); // R8
endmodule

// File: rtl/lane_clmul_unit.sv
module lane_clmul_unit #(
  parameter int LANES  = 4,
  parameter int STAGES = 2,
  parameter int HALF_W = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [LANES*2*HALF_W-1:0]    in_a,
  input  logic [LANES*2*HALF_W-1:0]    in_b,
  input  logic [lclmul_pkg::SEL_W-1:0] in_imm,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [LANES*2*HALF_W-1:0]    out_data
);
  import lclmul_pkg::*;

  localparam int LANE_W = 2 * HALF_W;
  localparam int VEC_W  = LANES * LANE_W;

  logic take_a_hi, take_b_hi;
  assign take_a_hi = in_imm[SEL_A_BIT];
  assign take_b_hi = in_imm[SEL_B_BIT];

  logic unused_sel_bits;
  assign unused_sel_bits = ^{in_imm[SEL_W-1:SEL_B_BIT+1], in_imm[SEL_B_BIT-1:SEL_A_BIT+1]};

  // Selected halves packed per lane as {b_half, a_half}.
  logic [VEC_W-1:0] sel_vec;
  logic [VEC_W-1:0] held_vec;
  logic [VEC_W-1:0] prod_vec;
  logic             mid_valid, mid_ready;

  for (genvar l = 0; l < LANES; l++) begin : g_sel
    clmul_half_sel #(.HALF_W(HALF_W)) u_sel (
      .lane_a   (in_a[l*LANE_W +: LANE_W]),
      .lane_b   (in_b[l*LANE_W +: LANE_W]),
      .take_a_hi(take_a_hi),
      .take_b_hi(take_b_hi),
      .a_half   (sel_vec[l*LANE_W +: HALF_W]),
      .b_half   (sel_vec[l*LANE_W+HALF_W +: HALF_W])
    );
  end

  if (STAGES >= 2) begin : g_front
    clmul_stage #(.W(VEC_W)) u_front (
      .clk     (clk),
      .rst     (rst),
      .up_valid(in_valid),
      .up_ready(in_ready),
      .up_data (sel_vec),
      .dn_valid(mid_valid),
      .dn_ready(mid_ready),
      .dn_data (held_vec)
    );
  end else begin : g_nofront
    assign held_vec  = sel_vec;
    assign mid_valid = in_valid;
    assign in_ready  = mid_ready;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mul
    clmul_core #(.HALF_W(HALF_W)) u_core (
      .mul_a(held_vec[l*LANE_W +: HALF_W]),
      .mul_b(held_vec[l*LANE_W+HALF_W +: HALF_W]),
      .prod (prod_vec[l*LANE_W +: LANE_W])
    );
  end

  clmul_stage #(.W(VEC_W)) u_back (
    .clk     (clk),
    .rst     (rst),
    .up_valid(mid_valid),
    .up_ready(mid_ready),
    .up_data (prod_vec),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (out_data)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid); // R9

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    AST_LANE_MSB_ZERO: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !out_data[l*LANE_W + LANE_W - 1]); // R6
  end
endmodule

// File: tb/sim_lane_clmul_unit.sv
module sim_lane_clmul_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int STAGES = 2;
  localparam int LW     = 128;
  localparam int VW     = LANES * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_a = '0;
  logic [VW-1:0] in_b = '0;
  logic [7:0]    in_imm = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [VW-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  int rdy_mode = 1; // 0 random, 1 forced high, 2 forced low
  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_clmul_unit #(.LANES(LANES), .STAGES(STAGES), .HALF_W(64)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [127:0] ref_mul(input logic [63:0] x, input logic [63:0] y);
    logic [127:0] r;
    r = '0;
    for (int k = 0; k < 127; k++) begin
      logic bitv;
      bitv = 1'b0;
      for (int i = 0; i < 64; i++)
        if (k - i >= 0 && k - i < 64) bitv = bitv ^ (x[i] & y[k-i]);
      r[k] = bitv;
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] ref_vec(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                            input logic [7:0] imm);
    logic [VW-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      logic [127:0] la, lb;
      la = a[l*LW +: LW];
      lb = b[l*LW +: LW];
      r[l*LW +: LW] = ref_mul(imm[0] ? la[127:64] : la[63:0], imm[4] ? lb[127:64] : lb[63:0]);
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic send(input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [7:0] imm,
                      input logic [VW-1:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_imm = imm;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((exp_q.size() != 0 || out_valid) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Consumer ready generator.
  initial begin
    forever begin
      @(negedge clk);
      case (rdy_mode)
        0: out_ready = ($urandom % 4) != 0;
        1: out_ready = 1'b1;
        default: out_ready = 1'b0;
      endcase
    end
  end

  // Output monitor: compares each transfer against the expected queue.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8 extra result got %h exp none", out_data);
        end else begin
          logic [VW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, out_data, e);
          for (int l = 0; l < LANES; l++)
            check_bit("R6 lane msb", out_data[l*LW + LW - 1], 1'b0);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got running exp finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [VW-1:0] ka, kb, ta, tb, d0, sq;
    void'($urandom(32'd20240611));

    // R9: reset state
    repeat (3) @(negedge clk);
    check_bit("R9 out_valid in reset", out_valid, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_bit("R9 out_valid after reset", out_valid, 1'b0);

    // R1: known answers, broadcast to every lane
    ka = {LANES{128'h7b5b546573745665_63746f725d53475d}};
    kb = {LANES{128'h4869285368617929_5b477565726f6e5d}};
    send(ka, kb, 8'h00, {LANES{128'h1d4d84c85c3440c0_929633d5d36f0451}}, "R1 known 00");
    send(ka, kb, 8'h11, {LANES{128'h1d1e1f2c592e7c45_d66ee03e410fd4ed}}, "R1 known 11");
    // R2 / R3: mixed half selections
    send(ka, kb, 8'h01, {LANES{128'h1a2bf6db3a30862f_babf262df4b7d5c9}}, "R2 known 01");
    send(ka, kb, 8'h10, {LANES{128'h1bd17c8d556ab5a1_7fa540ac2a281315}}, "R3 known 10");
    // R6: square of top bit of low half
    sq = {LANES{128'h0000000000000000_8000000000000000}};
    send(sq, sq, 8'h00, {LANES{128'h4000000000000000_0000000000000000}}, "R6 square");

    // R2/R3 with distinct random halves, all four selections
    ta = rnd_vec(); tb = rnd_vec();
    send(ta, tb, 8'h00, ref_vec(ta, tb, 8'h00), "R2 sel a lo b lo");
    send(ta, tb, 8'h01, ref_vec(ta, tb, 8'h01), "R2 sel a hi");
    send(ta, tb, 8'h10, ref_vec(ta, tb, 8'h10), "R3 sel b hi");
    send(ta, tb, 8'h11, ref_vec(ta, tb, 8'h11), "R3 sel both hi");
    // R4: unused selector bits set
    send(ta, tb, 8'hEE, ref_vec(ta, tb, 8'h00), "R4 unused bits 0xEE");
    send(ta, tb, 8'hFF, ref_vec(ta, tb, 8'h11), "R4 unused bits 0xFF");
    drain();

    // R7: latency with out_ready held high
    rdy_mode = 1;
    repeat (2) @(negedge clk);
    ta = rnd_vec(); tb = rnd_vec();
    send(ta, tb, 8'h10, ref_vec(ta, tb, 8'h10), "R7 latency data");
    for (int k = 0; k < STAGES - 1; k++) begin
      @(negedge clk); #1;
      check_bit("R7 not early", out_valid, 1'b0);
    end
    @(negedge clk); #1;
    check_bit("R7 valid at latency", out_valid, 1'b1);
    drain();

    // R8: stall holds result
    rdy_mode = 2;
    repeat (2) @(negedge clk);
    ta = rnd_vec(); tb = rnd_vec();
    send(ta, tb, 8'h01, ref_vec(ta, tb, 8'h01), "R8 stalled data");
    repeat (STAGES) @(negedge clk);
    #1;
    d0 = out_data;
    check_bit("R8 valid while stalled", out_valid, 1'b1);
    check("R8 stalled value", d0, ref_vec(ta, tb, 8'h01));
    repeat (3) @(negedge clk);
    #1;
    check_bit("R8 valid held", out_valid, 1'b1);
    check("R8 data stable", out_data, d0);
    rdy_mode = 1;
    drain();

    // R9: reset with a full pipeline discards everything
    rdy_mode = 2;
    repeat (2) @(negedge clk);
    for (int n = 0; n < STAGES; n++) begin
      ta = rnd_vec(); tb = rnd_vec();
      send(ta, tb, 8'h00, ref_vec(ta, tb, 8'h00), "R9 discarded");
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #1;
    check_bit("R9 reset clears full pipe", out_valid, 1'b0);
    exp_q.delete();
    tag_q.delete();
    rst = 1'b0;
    repeat (STAGES + 2) @(negedge clk);
    #1;
    check_bit("R9 nothing after reset", out_valid, 1'b0);

    // R5 / R8: random per-lane data under random back-pressure
    rdy_mode = 0;
    for (int n = 0; n < 300; n++) begin
      logic [7:0] im;
      ta = rnd_vec(); tb = rnd_vec();
      im = 8'($urandom);
      send(ta, tb, im, ref_vec(ta, tb, im), "R5 random lanes");
    end
    rdy_mode = 1;
    drain();
    check_bit("R8 queue empty at end", exp_q.size() == 0, 1'b1);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule